// File: doc/BRIEF.md
# I2C SCL Rate and Edge-Delay Generator

This block derives the serial clock of an I2C master from the core clock. A programmable divisor sets the SCL period. Each period opens with a low half and closes with a high half, and both halves are the same length. Two delay counts place strobes inside those halves. The update strobe tells the bit shifter when to put the next SDA bit on the line after SCL falls. The sample strobe tells it when to capture SDA after SCL rises. A bit tick marks the last core cycle of every SCL period.

The byte engine asks for clock periods by holding `run` high. Dropping `run` lets the current period finish, and SCL then parks released (high). Dropping `enable` parks SCL at once.

Divisor and delay values are captured only when a period starts, so a change in mid-period never deforms the waveform. The divisor's LSB is ignored. A delay of zero counts as one. A delay that does not fit inside its half is pulled back to the half's last cycle.

The sequencer has three states:
- PH_IDLE: SCL is released and no strobes are issued.
- PH_LOW: SCL is driven low.
- PH_HIGH: SCL is released for the high half.

Its transitions are:
- T_START: PH_IDLE to PH_LOW when enabled and running. The parameters are captured.
- T_RISE: PH_LOW to PH_HIGH after the last low cycle.
- T_NEXT: PH_HIGH to PH_LOW after the last high cycle while still enabled and running. The parameters are captured again.
- T_PARK: PH_HIGH to PH_IDLE after the last high cycle when `run` is low.
- T_ABORT: PH_LOW or PH_HIGH to PH_IDLE whenever `enable` is low.

Top module: `scl_timing_gen`

## Requirements
- R1: During and after reset, `scl_out` is 1 and `sda_update`, `sda_sample` and `bit_tick` are 0 until a period is started.
- R2: The half length H is `div_val[15:1]`, so the divisor's LSB is ignored. SCL is 0 for H core cycles and then 1 for H core cycles. The period is `div_val` rounded down to even.
- R3: Divisor values 0 and 1 behave as 2, giving H = 1 and a two-cycle period.
- R4: `sda_update` is a one-cycle pulse in each low half, in the cycle at offset F from the first low cycle (offset 0). F is the effective falling-edge delay.
- R5: `sda_sample` is a one-cycle pulse in each high half, in the cycle at offset R from the first high cycle (offset 0). R is the effective rising-edge delay.
- R6: A delay input of 0 is treated as 1.
- R7: An effective delay is limited to H-1, so each strobe stays inside its own half. With H = 1 the strobe coincides with the edge cycle.
- R8: `bit_tick` is high exactly in the last cycle of every period, which is the last high cycle.
- R9: With `enable` low, from the next cycle on `scl_out` is 1 and all strobes are 0, whatever `run` does.
- R10: When `run` goes low, the period in progress completes. SCL then stays at 1 with no strobes.
- R11: Divisor and delay inputs are captured only in the cycle a period is started. Changes made in mid-period apply from the next period.
- R12: When `run` stays high, the next period begins in the cycle right after `bit_tick`, with no idle cycle between periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low parks SCL at once |
| run | input | 1 | Request for SCL periods from the byte engine |
| div_val | input | 16 | Core clocks per SCL period (LSB ignored) |
| fall_dly | input | 16 | Core clocks from SCL fall to SDA update |
| rise_dly | input | 16 | Core clocks from SCL rise to SDA sample |
| scl_out | output | 1 | SCL level, 0 = drive low, 1 = released |
| sda_update | output | 1 | Strobe to drive the next SDA bit |
| sda_sample | output | 1 | Strobe to sample SDA |
| bit_tick | output | 1 | Pulse in the last cycle of each SCL period |

## Verification
The bench goes after the following corner cases:
- An odd divisor. A design that honours the LSB would stretch one half by a cycle.
- Divisors 0 and 1. A design that does not floor them would stall or wrap its counter.
- Zero delays and delays beyond the half. Without the rule for zero, a strobe would fire on the edge. Without the clamp, a strobe would spill into the other half or vanish.
- Changing the divisor and delays in mid-period. A design that does not take a snapshot would produce a malformed half.
- Dropping `run` in mid-period. A design that stops at once would truncate the bit.
- Dropping `enable`. A design that ignored it would keep toggling.
- Back-to-back periods. A design that inserted an idle cycle after the tick would drift the bit rate.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

endpackage

// File: rtl/scl_param_snap.sv
module scl_param_snap #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic [DLY_W-1:0] fall_in,
    input  logic [DLY_W-1:0] rise_in,
    output logic [DIV_W-2:0] half_q,
    output logic [DIV_W-2:0] fall_q,
    output logic [DIV_W-2:0] rise_q
);
    localparam int HW = DIV_W - 1;
    localparam int CW = (DLY_W > HW) ? DLY_W : HW;
    localparam logic [HW-1:0] H_ONE = HW'(1);

    logic [HW-1:0] half_n;
    logic [CW-1:0] lim_w;
    logic [DLY_W-1:0] dly_raw [2];
    logic [HW-1:0]    dly_eff [2];

    // Half length: divisor shifted right, never below one cycle (R2, R3)
    always_comb begin
        half_n = div_in[DIV_W-1:1];
        if (half_n == '0) begin
            half_n = H_ONE;
        end
        lim_w = CW'(half_n - H_ONE);
    end

    assign dly_raw[0] = fall_in;
    assign dly_raw[1] = rise_in;

    // Same rule for both delays: zero becomes one, cap at half-1 (R6, R7)
    for (genvar g = 0; g < 2; g++) begin : g_dly
        logic [CW-1:0] w;
        always_comb begin
            w = CW'(dly_raw[g]);
            if (w == '0) begin
                w = CW'(1);
            end
            if (w > lim_w) begin
                w = lim_w;
            end
            dly_eff[g] = w[HW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= H_ONE;
            fall_q <= '0;
            rise_q <= '0;
        end else if (load) begin
            half_q <= half_n;
            fall_q <= dly_eff[0];
            rise_q <= dly_eff[1];
        end
    end

    // R11: captured values move only on a period start
    p_hold_params_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({half_q, fall_q, rise_q}));

    // R7: captured strobe offsets always lie inside the half
    p_dly_in_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_q < half_q) && (rise_q < half_q));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int HW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          run,
    input  logic [HW-1:0] half_q,
    output phase_e        phase,
    output logic [HW-1:0] cnt,
    output logic          load
);
    localparam logic [HW-1:0] C_ONE = HW'(1);

    phase_e        phase_n;
    logic [HW-1:0] cnt_n;
    logic          last_cyc;

    assign last_cyc = (cnt == (half_q - C_ONE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            phase <= phase_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and load request
    always_comb begin
        phase_n = phase;
        cnt_n   = cnt;
        load    = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                cnt_n = '0;
                if (enable && run) begin          // T_START
                    phase_n = PH_LOW;
                    load    = 1'b1;
                end
            end
            PH_LOW: begin
                if (!enable) begin                // T_ABORT
                    phase_n = PH_IDLE;
                    cnt_n   = '0;
                end else if (last_cyc) begin      // T_RISE
                    phase_n = PH_HIGH;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + C_ONE;
                end
            end
            PH_HIGH: begin
                if (!enable) begin                // T_ABORT
                    phase_n = PH_IDLE;
                    cnt_n   = '0;
                end else if (last_cyc) begin
                    cnt_n = '0;
                    if (run) begin                // T_NEXT
                        phase_n = PH_LOW;
                        load    = 1'b1;
                    end else begin                // T_PARK
                        phase_n = PH_IDLE;
                    end
                end else begin
                    cnt_n = cnt + C_ONE;
                end
            end
            default: begin
                phase_n = PH_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // R2: the counter never passes the captured half length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |-> (cnt < half_q));

    // R11: a capture happens only when a low half is about to begin
    p_load_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (phase == PH_LOW) && (cnt == '0));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [DIV_W-1:0] div_val,
    input  logic [DLY_W-1:0] fall_dly,
    input  logic [DLY_W-1:0] rise_dly,
    output logic             scl_out,
    output logic             sda_update,
    output logic             sda_sample,
    output logic             bit_tick
);
    localparam int HW = DIV_W - 1;
    localparam logic [HW-1:0] T_ONE = HW'(1);

    phase_e        phase;
    logic [HW-1:0] cnt;
    logic          load;
    logic [HW-1:0] half_q;
    logic [HW-1:0] fall_q;
    logic [HW-1:0] rise_q;

    scl_param_snap #(
        .DIV_W (DIV_W),
        .DLY_W (DLY_W)
    ) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .div_in  (div_val),
        .fall_in (fall_dly),
        .rise_in (rise_dly),
        .half_q  (half_q),
        .fall_q  (fall_q),
        .rise_q  (rise_q)
    );

    scl_phase_fsm #(
        .HW (HW)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .run    (run),
        .half_q (half_q),
        .phase  (phase),
        .cnt    (cnt),
        .load   (load)
    );

    // Output process: decoded from the registered phase and count
    always_comb begin
        scl_out    = 1'b1;
        sda_update = 1'b0;
        sda_sample = 1'b0;
        bit_tick   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
            end
            PH_LOW: begin
                scl_out    = 1'b0;
                sda_update = (cnt == fall_q);
            end
            PH_HIGH: begin
                sda_sample = (cnt == rise_q);
                bit_tick   = (cnt == (half_q - T_ONE));
            end
            default: begin
            end
        endcase
    end

    // R9: a disabled block is quiet on the following cycle
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> scl_out && !sda_update && !sda_sample && !bit_tick);

    // R4: the update strobe only appears while SCL is low
    p_update_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sda_update |-> !scl_out);

    // R5: the sample strobe only appears while SCL is high
    p_sample_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_sample |-> scl_out);

    // R12: a tick with the request held is followed by a falling edge
    p_tick_next_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && enable && run) |=> $fell(scl_out));

    // R10: a tick without the request parks SCL high
    p_tick_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !run) |=> scl_out && !sda_update && !bit_tick);

endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        run = 1'b0;
    logic [15:0] div_val = 16'd8;
    logic [15:0] fall_dly = 16'd1;
    logic [15:0] rise_dly = 16'd1;
    logic        scl_out, sda_update, sda_sample, bit_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    scl_timing_gen uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .run        (run),
        .div_val    (div_val),
        .fall_dly   (fall_dly),
        .rise_dly   (rise_dly),
        .scl_out    (scl_out),
        .sda_update (sda_update),
        .sda_sample (sda_sample),
        .bit_tick   (bit_tick)
    );

    function automatic int eff_half(int d);
        int h;
        h = (d & 16'hFFFF) >> 1;
        if (h == 0) h = 1;
        return h;
    endfunction

    function automatic int eff_dly(int x, int h);
        int v;
        v = (x == 0) ? 1 : x;
        if (v > h - 1) v = h - 1;
        return v;
    endfunction

    task automatic check_out(string tag, logic [3:0] exp);
        logic [3:0] act;
        act = {scl_out, sda_update, sda_sample, bit_tick};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at t=%0t: {scl,upd,smp,tick} actual %b expected %b",
                     tag, $time, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against a model built from the requirements.
    // Parameter set 1 is applied after the sample at index chg_i,
    // and run is dropped after the sample at index drop_i.
    task automatic run_seq(string tag, int d0, int f0, int r0,
                           int d1, int f1, int r1, int chg_i, int drop_i);
        int k, pos, per, h, fe, re;
        bit run_m, chg_m, done;
        @(negedge clk);
        div_val = d0[15:0]; fall_dly = f0[15:0]; rise_dly = r0[15:0];
        enable = 1'b1; run = 1'b1;
        run_m = 1; chg_m = 0; done = 0; k = 0; pos = 0;
        per = 2; h = 1; fe = 0; re = 0;
        while (!done) begin
            if (pos == 0 && !run_m) begin
                done = 1;
            end else begin
                if (pos == 0) begin
                    h  = chg_m ? eff_half(d1) : eff_half(d0);
                    fe = chg_m ? eff_dly(f1, h) : eff_dly(f0, h);
                    re = chg_m ? eff_dly(r1, h) : eff_dly(r0, h);
                    per = 2 * h;
                end
                @(negedge clk);
                check_out(tag, {pos >= h, pos == fe, pos == h + re, pos == per - 1});
                if (k == chg_i) begin
                    div_val = d1[15:0]; fall_dly = f1[15:0]; rise_dly = r1[15:0];
                    chg_m = 1;
                end
                if (k == drop_i) begin
                    run = 1'b0; run_m = 0;
                end
                pos++;
                if (pos == per) pos = 0;
                k++;
            end
        end
        // R10: parked high, quiet
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_out({tag, " R10 park"}, 4'b1000);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        enable = 1'b1; run = 1'b1;
        repeat (3) @(negedge clk);
        check_out("R1 in reset", 4'b1000);
        run = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_out("R1 after reset", 4'b1000);
    endtask

    // R9: disable in mid-period
    task automatic t_disable();
        @(negedge clk);
        div_val = 16'd10; fall_dly = 16'd2; rise_dly = 16'd2;
        enable = 1'b1; run = 1'b1;
        repeat (4) @(negedge clk);
        check_out("R9 running low", {1'b0, 1'b0, 1'b0, 1'b0});
        enable = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check_out("R9 disabled", 4'b1000);
        end
        run = 1'b0;
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_out("R9 enabled idle", 4'b1000);
        end
    endtask

    initial begin
        t_reset();
        // R2 R4 R5 R8 R12: basic, three back-to-back periods
        run_seq("R2/R4/R5/R8/R12 div8", 8, 1, 2, 8, 1, 2, -1, 20);
        // R2: odd divisor acts as the even value below
        run_seq("R2 div9", 9, 2, 3, 9, 2, 3, -1, 9);
        // R3: divisor 1 and 0 act as 2
        run_seq("R3 div1", 1, 5, 5, 1, 5, 5, -1, 3);
        run_seq("R3 div0", 0, 0, 0, 0, 0, 0, -1, 2);
        // R6: zero delays become one
        run_seq("R6 zero dly", 12, 0, 0, 12, 0, 0, -1, 13);
        // R7: delays beyond the half are clamped
        run_seq("R7 clamp", 10, 100, 9, 10, 100, 9, -1, 12);
        // R10: run drop in mid-period completes the period
        run_seq("R10 mid drop", 10, 3, 1, 10, 3, 1, -1, 2);
        // R11: change in mid-period applies on next period
        run_seq("R11 change", 8, 1, 1, 14, 3, 5, 1, 10);
        // R11 with a longer period shortened in the high half
        run_seq("R11 shrink", 40, 7, 19, 6, 2, 2, 25, 45);
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule